// File: doc/BRIEF.md
# Erase-before-write paged storage array

This block models a small paged storage array that obeys the write rules of
floating-gate memory. Storage is split into blocks, and each block holds
several pages of bytes. A write can only clear bits. A bit goes back to 1 only
when its whole block is erased. Each page accepts exactly one program between
two erases of its block.

A host sends a command, which is an opcode plus a block and page address, over
a valid/ready handshake. For a program command, the host then streams one
page of bytes into the block. For a read command, the block streams one page
of bytes back. Both transfers move one byte per handshake, lowest byte first.
While an operation is in progress, a busy output stays high for a fixed
latency per command type, and no new command is taken. Each operation ends
with a one-cycle `done` pulse. The `status` code returned with that pulse
reports success, a rejected second program, or an illegal opcode.

Top module: `nand_page_store`

## Requirements
- R1: After reset, `busy`, `done`, `wr_ready` and `rd_valid` are low and `cmd_ready` is high. Every byte of every page reads as 8'hFF, and every page accepts its first program.
- R2: Erase (opcode 2'b11) sets every byte of every page in the addressed block to 8'hFF. It lets each of those pages be programmed again. Pages of other blocks keep their contents.
- R3: After the first program of a page since its block was erased, a read of that page returns the written bytes, because each stored bit becomes the old bit AND the written bit.
- R4: A program to a page that is already programmed still takes its page of bytes. It then ends with status 2'd1 and no busy period, and it leaves the page contents unchanged.
- R5: Programming one page leaves the other pages of the same block unchanged, and they can still be programmed.
- R6: `busy` stays high for exactly READ_LAT (4) cycles for a read, PROG_LAT (16) cycles for an accepted program and ERASE_LAT (64) cycles for an erase.
- R7: While an operation is in progress, `cmd_ready` is low. A `cmd_valid` presented then has no effect on the array and produces no `done`.
- R8: Page bytes move one per cycle in which valid and ready are both high, byte 0 first. While `rd_ready` is low, `rd_data` and `rd_valid` hold.
- R9: Opcode 2'b01 is read, 2'b10 is program, 2'b11 is erase. Opcode 2'b00 ends on the next cycle with status 2'd2 and touches nothing.
- R10: Each completed command raises `done` for one cycle with `status` 2'd0 on success, and the block is then ready for a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 2 | Opcode: 01 read, 10 program, 11 erase, 00 illegal |
| cmd_block | input | BLK_W (2) | Block address |
| cmd_page | input | PG_W (2) | Page address within the block |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken this cycle if valid |
| wr_data | input | DATA_W (8) | Program byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | DATA_W (8) | Read byte |
| busy | output | 1 | Fixed-latency operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion code: 0 ok, 1 program rejected, 2 illegal opcode |

## Verification
The bench targets the repeat-program corner: it programs a page twice without an erase. A design that did not track programmed pages would clear more bits and show altered bytes on readback. A design that rejected the command late would show a spurious busy period. It erases one block and rereads pages both inside and outside that block. A wrong erase scope shows up as surviving data or lost neighbours, and a missing flag clear shows up as a rejected reprogram. It also offers commands during a busy window and stalls both byte streams, which exposes a design that accepts commands early or drops or reorders bytes.

// File: rtl/nps_pkg.sv
package nps_pkg;

   typedef enum logic [1:0] {
      OP_ILLEGAL = 2'b00,
      OP_READ    = 2'b01,
      OP_PROG    = 2'b10,
      OP_ERASE   = 2'b11
   } nps_op_e;

   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_REJECT  = 2'd1,
      ST_BADOP   = 2'd2,
      ST_SPARE   = 2'd3
   } nps_status_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_LOAD,
      S_WAIT,
      S_STREAM
   } nps_state_e;

endpackage

// File: rtl/nps_busy_timer.sv
module nps_busy_timer #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= start_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/nps_page_buffer.sv
module nps_page_buffer #(
   parameter int PAGE_BYTES = 16,
   parameter int DATA_W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [PAGE_BYTES*DATA_W-1:0] load_data,
   input  logic                         shift_in,
   input  logic [DATA_W-1:0]            byte_in,
   input  logic                         shift_out,
   output logic [DATA_W-1:0]            byte_out,
   output logic [PAGE_BYTES*DATA_W-1:0] page_out
);

   localparam int PAGE_BITS = PAGE_BYTES * DATA_W;

   logic [PAGE_BITS-1:0] buf_q;
   logic [PAGE_BITS-1:0] in_next;
   logic [PAGE_BITS-1:0] out_next;

   generate
      if (PAGE_BYTES == 1) begin : g_single
         assign in_next  = byte_in;
         assign out_next = '1;
      end else begin : g_shift
         assign in_next  = {byte_in, buf_q[PAGE_BITS-1:DATA_W]};
         assign out_next = {{DATA_W{1'b1}}, buf_q[PAGE_BITS-1:DATA_W]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         buf_q <= '1;
      else if (load)
         buf_q <= load_data;
      else if (shift_in)
         buf_q <= in_next;
      else if (shift_out)
         buf_q <= out_next;
   end

   assign byte_out = buf_q[DATA_W-1:0];
   assign page_out = buf_q;

endmodule

// File: rtl/nps_page_array.sv
module nps_page_array #(
   parameter int NUM_BLOCKS      = 4,
   parameter int PAGES_PER_BLOCK = 4,
   parameter int PAGE_BYTES      = 16,
   parameter int DATA_W          = 8,
   parameter int BLK_W           = 2,
   parameter int PIDX_W          = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PIDX_W-1:0]            page_idx,
   output logic [PAGE_BYTES*DATA_W-1:0] page_rd,
   output logic                         page_used,
   input  logic                         prog_en,
   input  logic [PAGE_BYTES*DATA_W-1:0] prog_data,
   input  logic                         erase_en,
   input  logic [BLK_W-1:0]             erase_blk
);

   localparam int PAGE_BITS = PAGE_BYTES * DATA_W;
   localparam int NUM_PAGES = NUM_BLOCKS * PAGES_PER_BLOCK;

   logic [NUM_PAGES*PAGE_BITS-1:0] cells_flat;
   logic [NUM_PAGES-1:0]           used_flat;

   generate
      for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
         for (genvar p = 0; p < PAGES_PER_BLOCK; p++) begin : g_pg
            localparam int IDX = b * PAGES_PER_BLOCK + p;
            logic [PAGE_BITS-1:0] cells_q;
            logic                 used_q;
            logic                 hit_erase;
            logic                 hit_prog;

            assign hit_erase = erase_en && (erase_blk == BLK_W'(b));
            assign hit_prog  = prog_en && (page_idx == PIDX_W'(IDX)) && !used_q;

            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  cells_q <= '1;
                  used_q  <= 1'b0;
               end else if (hit_erase) begin
                  cells_q <= '1;
                  used_q  <= 1'b0;
               end else if (hit_prog) begin
                  cells_q <= cells_q & prog_data;
                  used_q  <= 1'b1;
               end
            end

            assign cells_flat[IDX*PAGE_BITS +: PAGE_BITS] = cells_q;
            assign used_flat[IDX]                        = used_q;
         end
      end
   endgenerate

   assign page_rd   = cells_flat[int'(page_idx)*PAGE_BITS +: PAGE_BITS];
   assign page_used = used_flat[page_idx];

endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
   import nps_pkg::*;
#(
   parameter int PAGE_BYTES = 16,
   parameter int BLK_W      = 2,
   parameter int PG_W       = 2,
   parameter int READ_LAT   = 4,
   parameter int PROG_LAT   = 16,
   parameter int ERASE_LAT  = 64,
   parameter int CNT_W      = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [1:0]            cmd_op,
   input  logic [BLK_W-1:0]      cmd_block,
   input  logic [PG_W-1:0]       cmd_page,
   output logic                  cmd_ready,
   input  logic                  wr_valid,
   output logic                  wr_ready,
   output logic                  rd_valid,
   input  logic                  rd_ready,
   output logic                  busy,
   output logic                  done,
   output logic [1:0]            status,
   output logic [BLK_W+PG_W-1:0] page_idx,
   input  logic                  page_used,
   output logic                  buf_load,
   output logic                  buf_shift_in,
   output logic                  buf_shift_out,
   output logic                  prog_en,
   output logic                  erase_en,
   output logic [BLK_W-1:0]      erase_blk,
   output logic                  timer_start,
   output logic [CNT_W-1:0]      timer_val,
   input  logic                  timer_zero
);

   localparam int BC_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

   nps_state_e          state_q;
   nps_op_e             op_q;
   logic [BLK_W-1:0]    blk_q;
   logic [PG_W-1:0]     pg_q;
   logic [BC_W-1:0]     bc_q;
   logic                done_q;
   nps_status_e         status_q;

   logic accept, wr_fire, rd_fire, last, wait_end;

   assign accept   = (state_q == S_IDLE) && cmd_valid;
   assign wr_fire  = (state_q == S_LOAD) && wr_valid;
   assign rd_fire  = (state_q == S_STREAM) && rd_ready;
   assign last     = (bc_q == BC_W'(PAGE_BYTES - 1));
   assign wait_end = (state_q == S_WAIT) && timer_zero;

   always_comb begin
      timer_start = 1'b0;
      timer_val   = '0;
      if (accept && (cmd_op == OP_READ)) begin
         timer_start = 1'b1;
         timer_val   = CNT_W'(READ_LAT - 1);
      end else if (accept && (cmd_op == OP_ERASE)) begin
         timer_start = 1'b1;
         timer_val   = CNT_W'(ERASE_LAT - 1);
      end else if (wr_fire && last && !page_used) begin
         timer_start = 1'b1;
         timer_val   = CNT_W'(PROG_LAT - 1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         op_q     <= OP_ILLEGAL;
         blk_q    <= '0;
         pg_q     <= '0;
         bc_q     <= '0;
         done_q   <= 1'b0;
         status_q <= ST_OK;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (cmd_valid) begin
                  op_q  <= nps_op_e'(cmd_op);
                  blk_q <= cmd_block;
                  pg_q  <= cmd_page;
                  bc_q  <= '0;
                  case (nps_op_e'(cmd_op))
                     OP_READ, OP_ERASE: state_q <= S_WAIT;
                     OP_PROG:           state_q <= S_LOAD;
                     default: begin
                        done_q   <= 1'b1;
                        status_q <= ST_BADOP;
                     end
                  endcase
               end
            end
            S_LOAD: begin
               if (wr_valid) begin
                  if (last) begin
                     if (page_used) begin
                        state_q  <= S_IDLE;
                        done_q   <= 1'b1;
                        status_q <= ST_REJECT;
                     end else begin
                        state_q <= S_WAIT;
                     end
                  end else begin
                     bc_q <= bc_q + 1'b1;
                  end
               end
            end
            S_WAIT: begin
               if (timer_zero) begin
                  if (op_q == OP_READ) begin
                     state_q <= S_STREAM;
                     bc_q    <= '0;
                  end else begin
                     state_q  <= S_IDLE;
                     done_q   <= 1'b1;
                     status_q <= ST_OK;
                  end
               end
            end
            S_STREAM: begin
               if (rd_ready) begin
                  if (last) begin
                     state_q  <= S_IDLE;
                     done_q   <= 1'b1;
                     status_q <= ST_OK;
                  end else begin
                     bc_q <= bc_q + 1'b1;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign cmd_ready     = (state_q == S_IDLE);
   assign wr_ready      = (state_q == S_LOAD);
   assign rd_valid      = (state_q == S_STREAM);
   assign busy          = (state_q == S_WAIT);
   assign done          = done_q;
   assign status        = status_q;
   assign page_idx      = {blk_q, pg_q};
   assign erase_blk     = blk_q;
   assign buf_shift_in  = wr_fire;
   assign buf_shift_out = rd_fire;
   assign buf_load      = wait_end && (op_q == OP_READ);
   assign prog_en       = wait_end && (op_q == OP_PROG);
   assign erase_en      = wait_end && (op_q == OP_ERASE);

endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
   parameter int NUM_BLOCKS      = 4,
   parameter int PAGES_PER_BLOCK = 4,
   parameter int PAGE_BYTES      = 16,
   parameter int DATA_W          = 8,
   parameter int READ_LAT        = 4,
   parameter int PROG_LAT        = 16,
   parameter int ERASE_LAT       = 64,
   localparam int BLK_W          = $clog2(NUM_BLOCKS),
   localparam int PG_W           = $clog2(PAGES_PER_BLOCK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [BLK_W-1:0]  cmd_block,
   input  logic [PG_W-1:0]   cmd_page,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status
);

   localparam int PAGE_BITS = PAGE_BYTES * DATA_W;
   localparam int PIDX_W    = BLK_W + PG_W;
   localparam int MAX_LAT   = (ERASE_LAT > PROG_LAT) ?
                              ((ERASE_LAT > READ_LAT) ? ERASE_LAT : READ_LAT) :
                              ((PROG_LAT > READ_LAT) ? PROG_LAT : READ_LAT);
   localparam int CNT_W     = $clog2(MAX_LAT + 1);

   generate
      if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_blocks
         $error("NUM_BLOCKS must be a power of two of at least 2");
      end
      if (PAGES_PER_BLOCK < 2 || (PAGES_PER_BLOCK & (PAGES_PER_BLOCK - 1)) != 0) begin : g_bad_pages
         $error("PAGES_PER_BLOCK must be a power of two of at least 2");
      end
      if (PAGE_BYTES < 1 || DATA_W < 1) begin : g_bad_page
         $error("PAGE_BYTES and DATA_W must be positive");
      end
      if (READ_LAT < 1 || PROG_LAT < 1 || ERASE_LAT < 1) begin : g_bad_lat
         $error("latencies must be at least one cycle");
      end
   endgenerate

   logic [PIDX_W-1:0]    page_idx;
   logic [PAGE_BITS-1:0] page_rd;
   logic [PAGE_BITS-1:0] buf_page;
   logic                 page_used;
   logic                 buf_load, buf_shift_in, buf_shift_out;
   logic                 prog_en, erase_en;
   logic [BLK_W-1:0]     erase_blk;
   logic                 timer_start, timer_zero;
   logic [CNT_W-1:0]     timer_val;

   nps_ctrl #(
      .PAGE_BYTES (PAGE_BYTES),
      .BLK_W      (BLK_W),
      .PG_W       (PG_W),
      .READ_LAT   (READ_LAT),
      .PROG_LAT   (PROG_LAT),
      .ERASE_LAT  (ERASE_LAT),
      .CNT_W      (CNT_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_op        (cmd_op),
      .cmd_block     (cmd_block),
      .cmd_page      (cmd_page),
      .cmd_ready     (cmd_ready),
      .wr_valid      (wr_valid),
      .wr_ready      (wr_ready),
      .rd_valid      (rd_valid),
      .rd_ready      (rd_ready),
      .busy          (busy),
      .done          (done),
      .status        (status),
      .page_idx      (page_idx),
      .page_used     (page_used),
      .buf_load      (buf_load),
      .buf_shift_in  (buf_shift_in),
      .buf_shift_out (buf_shift_out),
      .prog_en       (prog_en),
      .erase_en      (erase_en),
      .erase_blk     (erase_blk),
      .timer_start   (timer_start),
      .timer_val     (timer_val),
      .timer_zero    (timer_zero)
   );

   nps_busy_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (timer_start),
      .start_val (timer_val),
      .zero      (timer_zero)
   );

   nps_page_buffer #(
      .PAGE_BYTES (PAGE_BYTES),
      .DATA_W     (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (buf_load),
      .load_data (page_rd),
      .shift_in  (buf_shift_in),
      .byte_in   (wr_data),
      .shift_out (buf_shift_out),
      .byte_out  (rd_data),
      .page_out  (buf_page)
   );

   nps_page_array #(
      .NUM_BLOCKS      (NUM_BLOCKS),
      .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
      .PAGE_BYTES      (PAGE_BYTES),
      .DATA_W          (DATA_W),
      .BLK_W           (BLK_W),
      .PIDX_W          (PIDX_W)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .page_idx  (page_idx),
      .page_rd   (page_rd),
      .page_used (page_used),
      .prog_en   (prog_en),
      .prog_data (buf_page),
      .erase_en  (erase_en),
      .erase_blk (erase_blk)
   );

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
   parameter int DATA_W    = 8,
   parameter int READ_LAT  = 4,
   parameter int PROG_LAT  = 16,
   parameter int ERASE_LAT = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_op,
   input logic              wr_ready,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy,
   input logic              done,
   input logic [1:0]        status
);

   logic [31:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (busy)
         run_q <= run_q + 1'b1;
      else
         run_q <= '0;
   end

   assert_busy_blocks_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cmd_ready);

   assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && run_q != 0) |-> (run_q == READ_LAT || run_q == PROG_LAT || run_q == ERASE_LAT));

   assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   assert_streams_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ready && rd_valid));

   assert_badop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_op == 2'b00) |=> (done && status == 2'd2));

   assert_reject_nowait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd1) |-> ($past(wr_ready) && !$past(busy)));

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

endmodule

bind nand_page_store nps_checker #(
   .DATA_W    (DATA_W),
   .READ_LAT  (READ_LAT),
   .PROG_LAT  (PROG_LAT),
   .ERASE_LAT (ERASE_LAT)
) u_nps_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .wr_ready  (wr_ready),
   .rd_valid  (rd_valid),
   .rd_ready  (rd_ready),
   .rd_data   (rd_data),
   .busy      (busy),
   .done      (done),
   .status    (status)
);

// File: tb/nand_page_store_bench.sv
module nand_page_store_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NB  = 4;
   localparam int PPB = 4;
   localparam int PB  = 16;
   localparam int NP  = NB * PPB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [1:0] cmd_op = 2'b00;
   logic [1:0] cmd_block = '0;
   logic [1:0] cmd_page = '0;
   logic       wr_valid = 1'b0;
   logic       wr_ready;
   logic [7:0] wr_data = '0;
   logic       rd_valid;
   logic       rd_ready = 1'b0;
   logic [7:0] rd_data;
   logic       busy;
   logic       done;
   logic [1:0] status;

   nand_page_store u_nand_page_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_op    (cmd_op),
      .cmd_block (cmd_block),
      .cmd_page  (cmd_page),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .wr_data   (wr_data),
      .rd_valid  (rd_valid),
      .rd_ready  (rd_ready),
      .rd_data   (rd_data),
      .busy      (busy),
      .done      (done),
      .status    (status)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [7:0] model [NP][PB];
   bit         used  [NP];
   logic [7:0] exp_bytes[$];
   int         exp_lat[$];
   int         exp_st[$];
   string      rd_tag = "R1";
   int         n_chk = 0;
   int         n_bad = 0;
   bit         stall_rd = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Monitor: read bytes against the scoreboard
   initial forever begin
      @(negedge clk);
      if (rst_n && rd_valid && rd_ready) begin
         if (exp_bytes.size() == 0)
            check(1'b0, "R8", "unexpected read byte", int'(rd_data), -1);
         else begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            check(rd_data == e, rd_tag, "read byte", int'(rd_data), int'(e));
         end
      end
   end

   // Monitor: completion status (R10)
   initial forever begin
      @(negedge clk);
      if (rst_n && done) begin
         if (exp_st.size() == 0)
            check(1'b0, "R7", "unexpected done", int'(status), -1);
         else begin
            int e;
            e = exp_st.pop_front();
            check(int'(status) == e, "R10", "status", int'(status), e);
         end
      end
   end

   // Monitor: busy window length (R6)
   initial begin
      int run;
      run = 0;
      forever begin
         @(negedge clk);
         if (rst_n && busy) run++;
         else if (run != 0) begin
            if (exp_lat.size() == 0)
               check(1'b0, "R6", "unexpected busy window", run, 0);
            else begin
               int e;
               e = exp_lat.pop_front();
               check(run == e, "R6", "busy cycles", run, e);
            end
            run = 0;
         end
      end
   end

   // Read-side back-pressure pattern
   initial begin
      int cyc;
      cyc = 0;
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         rd_ready = stall_rd ? ((cyc % 3) != 2) : 1'b1;
      end
   end

   task automatic issue(input logic [1:0] op, input int blk, input int pg);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_op    = op;
      cmd_block = 2'(blk);
      cmd_page  = 2'(pg);
      cmd_valid = 1'b1;
      @(posedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (exp_st.size() != 0 || exp_bytes.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic do_read(input int blk, input int pg, input string tag);
      int idx;
      idx = blk * PPB + pg;
      rd_tag = tag;
      for (int i = 0; i < PB; i++) exp_bytes.push_back(model[idx][i]);
      exp_lat.push_back(4);
      exp_st.push_back(0);
      issue(2'b01, blk, pg);
      wait_idle();
   endtask

   task automatic do_prog(input int blk, input int pg, input logic [7:0] seed,
                          input int gap);
      int idx;
      logic [7:0] d [PB];
      idx = blk * PPB + pg;
      for (int i = 0; i < PB; i++) d[i] = 8'(seed + i * 37);
      if (used[idx]) exp_st.push_back(1);
      else begin
         exp_lat.push_back(16);
         exp_st.push_back(0);
         for (int i = 0; i < PB; i++) model[idx][i] = model[idx][i] & d[i];
         used[idx] = 1'b1;
      end
      issue(2'b10, blk, pg);
      for (int i = 0; i < PB; i++) begin
         @(negedge clk);
         if (gap != 0 && (i % gap) == 1) begin
            wr_valid = 1'b0;
            @(negedge clk);
         end
         wr_valid = 1'b1;
         wr_data  = d[i];
         while (!wr_ready) @(negedge clk);
         @(posedge clk);
         #1 wr_valid = 1'b0;
      end
      wait_idle();
   endtask

   task automatic do_erase(input int blk, input bit poke);
      exp_lat.push_back(64);
      exp_st.push_back(0);
      for (int p = 0; p < PPB; p++) begin
         used[blk * PPB + p] = 1'b0;
         for (int i = 0; i < PB; i++) model[blk * PPB + p][i] = 8'hFF;
      end
      issue(2'b11, blk, 0);
      if (poke) begin
         repeat (3) @(negedge clk);
         cmd_op = 2'b10; cmd_block = 2'd2; cmd_page = 2'd3; cmd_valid = 1'b1;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(cmd_ready == 1'b0, "R7", "cmd_ready while busy", int'(cmd_ready), 0);
         end
         cmd_valid = 1'b0;
         check(busy == 1'b1, "R7", "busy during erase", int'(busy), 1);
      end
      wait_idle();
   endtask

   initial begin
      for (int p = 0; p < NP; p++) begin
         used[p] = 1'b0;
         for (int i = 0; i < PB; i++) model[p][i] = 8'hFF;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      check(busy == 1'b0,      "R1", "busy after reset",      int'(busy), 0);
      check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
      check(done == 1'b0,      "R1", "done after reset",      int'(done), 0);
      check(rd_valid == 1'b0,  "R1", "rd_valid after reset",  int'(rd_valid), 0);
      check(wr_ready == 1'b0,  "R1", "wr_ready after reset",  int'(wr_ready), 0);

      do_read(0, 0, "R1");                 // R1: erased contents after reset
      do_read(3, 3, "R1");

      do_prog(0, 0, 8'h5A, 3);             // R3: first program accepted, gaps on input
      stall_rd = 1'b1;
      do_read(0, 0, "R3");                 // R8: stalled read keeps order
      stall_rd = 1'b0;

      do_prog(0, 0, 8'h00, 0);             // R4: second program rejected, no busy
      do_read(0, 0, "R4");

      do_prog(0, 1, 8'hC3, 0);             // R5: neighbour page in same block
      do_read(0, 1, "R5");
      do_read(0, 0, "R5");
      do_prog(1, 2, 8'h11, 4);
      do_read(1, 2, "R5");

      do_erase(0, 1'b1);                   // R2 with R7 command offered while busy
      do_read(0, 0, "R2");
      do_read(0, 1, "R2");
      do_read(1, 2, "R2");                 // R2: other block untouched
      do_read(2, 3, "R7");                 // R7: ignored program left page erased

      do_prog(0, 0, 8'hA7, 0);             // R2: flag cleared by erase
      do_read(0, 0, "R2");
      do_prog(2, 3, 8'h3C, 0);             // R7: page still programmable
      do_read(2, 3, "R7");

      exp_st.push_back(2);                 // R9: illegal opcode
      issue(2'b00, 1, 2);
      wait_idle();
      do_read(1, 2, "R9");

      do_erase(3, 1'b0);
      do_prog(3, 3, 8'hF0, 2);
      stall_rd = 1'b1;
      do_read(3, 3, "R8");
      stall_rd = 1'b0;

      repeat (5) @(negedge clk);
      check(exp_lat.size() == 0, "R6", "pending busy windows", exp_lat.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule